// File: doc/BRIEF.md
# Reset Sequencer with Power-On Stretch

This block generates the single internal reset of a small 8-bit microcontroller core. Two sources can request it. The first is an active-low reset pin. The second is a power-on path that watches a digital supply-good signal and is switched on by a configuration bit. The pin asserts the core reset at once, without waiting for a clock. When the pin returns high, the reset is released only after the pin level has passed through a two-stage synchronizer, so the release always falls on a clock edge.

When the power-on path is enabled, a rising edge on supply-good loads a 12-bit down-counter with all ones. The counter then counts down once per instruction cycle. An instruction cycle is a fixed number of clocks, set by a parameter. The core stays in reset until the counter passes zero, which takes 4096 instruction cycles. After that release, the path does nothing more while supply-good stays high. It is armed again only when supply-good drops.

While the core reset is active, the block also drives the reset-time controls of its neighbours:
- direction controls that put four port groups into high impedance,
- a drive-high control for a fifth port,
- a program counter clear,
- clears for six control registers,
- a stack pointer load together with its initial value.

The initial stack pointer value follows from the RAM size. A falling edge on the reset pin also produces a one-clock pulse that takes the core out of its halted low-power state.

Top module: `rst_seq`

## Requirements
- R1: A low level on `ext_rst_n` sets `core_rst` high immediately, with no clock edge needed, and keeps it high while the pin stays low.
- R2: When the power-on path is not holding reset, `core_rst` falls on the third rising clock edge after `ext_rst_n` returns high. The edge after the rise is counted as the first.
- R3: With `por_en` high, `core_rst` is held high while `supply_ok` is low. A rise of `supply_ok` loads the 12-bit counter with 0xFFF. The counter steps down once every `CYC_DIV` clocks, and the step taken at zero ends the stretch. `core_rst` falls on edge 4096*`CYC_DIV`+4 after the rise, where the first edge after the rise is counted as 1.
- R4: With `por_en` low, `supply_ok` has no effect: `core_rst` follows only the pin, both while the supply is low and when it rises.
- R5: After a power-on stretch ends, or after a supply rise seen with `por_en` low, `core_rst` does not rise again while `supply_ok` stays high and the pin stays high. Toggling `por_en` in that state does not restart the stretch.
- R6: A drop of `supply_ok` re-arms the power-on path. With `por_en` high, `core_rst` goes high within four clocks of the drop, and the next rise gives a complete new stretch of the same length as in R3.
- R7: While `core_rst` is high, every bit of `tri_en` is 1 (the port group is in high impedance) and `hi_drive` is 1. Both are 0 when `core_rst` is low.
- R8: While `core_rst` is high, `pc_clear` is 1, all six bits of `reg_clear` are 1 and `sp_load` is 1. All three are 0 when `core_rst` is low. `sp_init` equals `RAM_BYTES`-17, which is 0x2F for 64 bytes and 0x6F for 128 bytes.
- R9: A fall of `ext_rst_n` makes `halt_exit` high for exactly one clock, starting after the first rising edge that follows the fall. A power-on stretch never produces this pulse.
- R10: Clearing `por_en` during a stretch cancels it: `core_rst` falls on the next rising clock edge, provided the pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| ext_rst_n | input | 1 | Reset pin, active low, asynchronous |
| supply_ok | input | 1 | Digital supply-good level from the analog detector |
| por_en | input | 1 | Enables the power-on reset path (configuration bit) |
| core_rst | output | 1 | Internal reset of the core, active high |
| halt_exit | output | 1 | One-clock pulse that wakes a halted core |
| tri_en | output | NUM_TRI | Per-group high-impedance control for four port groups |
| hi_drive | output | 1 | Forces the fifth port group to drive high |
| pc_clear | output | 1 | Clears the program counter to 0x0000 |
| reg_clear | output | NUM_CLR | Clears for the six control registers |
| sp_load | output | 1 | Loads the stack pointer with `sp_init` |
| sp_init | output | SP_W | Reset value of the stack pointer |

## Verification
A wrong count or a wrong divider phase in the power-on path shows up as a release of `core_rst` that is too early or too late. This error appears only once per stretch, about 4096 instruction cycles after the supply rise, so the bench measures the exact release edge in both a first and a re-armed stretch. A power-on state machine that does not stay finished shows up as a spurious rise of `core_rst` within a few clocks of a `por_en` toggle while the supply is high. A synchronizer of the wrong depth, or a wrong edge detector, shifts the release after the pin by whole cycles, or moves or repeats the `halt_exit` pulse. All of these are visible within three clocks of the pin change.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    POR_ARMED = 2'd0,
    POR_COUNT = 2'd1,
    POR_DONE  = 2'd2
  } por_state_t;

  // Stack pointer reset value: top of RAM window minus the register area.
  function automatic int sp_reset_value(input int ram_bytes);
    return ram_bytes - 17;
  endfunction

endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync (
  input  logic clk,
  input  logic pin_n,
  output logic pin_ok,
  output logic halt_pulse
);
  logic [1:0] sync_q;
  logic       ok_d;
  logic       pulse_q;

  // Asynchronous clear so the low level is seen at once; release through two stages.
  always_ff @(posedge clk or negedge pin_n) begin
    if (!pin_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  // Edge detect of the synchronized level: one pulse per pin assertion.
  always_ff @(posedge clk) begin
    ok_d    <= sync_q[1];
    pulse_q <= ok_d & ~sync_q[1];
  end

  assign pin_ok     = sync_q[1];
  assign halt_pulse = pulse_q;
endmodule

// File: rtl/rst_por_timer.sv
module rst_por_timer
  import rst_seq_pkg::*;
#(
  parameter int CYC_DIV = 10,
  parameter int TMR_W   = 12
) (
  input  logic clk,
  input  logic supply_ok,
  input  logic por_en,
  output logic por_hold
);
  localparam logic [TMR_W-1:0] PRESET = {TMR_W{1'b1}};

  logic [1:0]       sup_q;
  logic             sup_prev;
  por_state_t       state;
  logic [TMR_W-1:0] timer;
  logic             tick;

  generate
    if (CYC_DIV > 1) begin : g_div
      localparam int DIV_W = $clog2(CYC_DIV);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CYC_DIV - 1);
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk) begin
        if (state != POR_COUNT || div_q == DIV_LAST) div_q <= '0;
        else                                       div_q <= div_q + 1'b1;
      end
      assign tick = (state == POR_COUNT) && (div_q == DIV_LAST);
    end else begin : g_nodiv
      assign tick = (state == POR_COUNT);
    end
  endgenerate

  always_ff @(posedge clk) begin
    sup_q    <= {sup_q[0], supply_ok};
    sup_prev <= sup_q[1];
    if (!sup_q[1]) begin
      state <= POR_ARMED;
      timer <= PRESET;
    end else begin
      unique case (state)
        POR_ARMED: begin
          if (!sup_prev) begin
            state <= por_en ? POR_COUNT : POR_DONE;
            timer <= PRESET;
          end
        end
        POR_COUNT: begin
          if (!por_en)             state <= POR_DONE;
          else if (tick) begin
            if (timer == '0)       state <= POR_DONE;
            else                   timer <= timer - 1'b1;
          end
        end
        default: state <= POR_DONE;
      endcase
    end
  end

  assign por_hold = por_en && (state != POR_DONE);
endmodule

// File: rtl/rst_defaults.sv
module rst_defaults
  import rst_seq_pkg::*;
#(
  parameter int NUM_TRI   = 4,
  parameter int NUM_CLR   = 6,
  parameter int SP_W      = 8,
  parameter int RAM_BYTES = 64
) (
  input  logic               clk,
  input  logic               ext_rst_n,
  input  logic               rst_next,
  output logic [NUM_TRI-1:0] tri_en,
  output logic               hi_drive,
  output logic               pc_clear,
  output logic [NUM_CLR-1:0] reg_clear,
  output logic               sp_load,
  output logic [SP_W-1:0]    sp_init
);
  localparam logic [SP_W-1:0] SP_RST = SP_W'(sp_reset_value(RAM_BYTES));

  generate
    for (genvar i = 0; i < NUM_TRI; i++) begin : g_tri
      always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n) tri_en[i] <= 1'b1;
        else            tri_en[i] <= rst_next;
      end
    end
    for (genvar j = 0; j < NUM_CLR; j++) begin : g_clr
      always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n) reg_clear[j] <= 1'b1;
        else            reg_clear[j] <= rst_next;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n) begin
      hi_drive <= 1'b1;
      pc_clear <= 1'b1;
      sp_load  <= 1'b1;
    end else begin
      hi_drive <= rst_next;
      pc_clear <= rst_next;
      sp_load  <= rst_next;
    end
  end

  assign sp_init = SP_RST;
endmodule

// File: rtl/rst_seq.sv
module rst_seq #(
  parameter int CYC_DIV   = 10,
  parameter int TMR_W     = 12,
  parameter int RAM_BYTES = 64,
  parameter int NUM_TRI   = 4,
  parameter int NUM_CLR   = 6,
  parameter int SP_W      = 8
) (
  input  logic               clk,
  input  logic               ext_rst_n,
  input  logic               supply_ok,
  input  logic               por_en,
  output logic               core_rst,
  output logic               halt_exit,
  output logic [NUM_TRI-1:0] tri_en,
  output logic               hi_drive,
  output logic               pc_clear,
  output logic [NUM_CLR-1:0] reg_clear,
  output logic               sp_load,
  output logic [SP_W-1:0]    sp_init
);
  logic pin_ok;
  logic por_hold;
  logic rst_next;
  logic rst_q;

  rst_pin_sync u_pin (
    .clk        (clk),
    .pin_n      (ext_rst_n),
    .pin_ok     (pin_ok),
    .halt_pulse (halt_exit)
  );

  rst_por_timer #(
    .CYC_DIV (CYC_DIV),
    .TMR_W   (TMR_W)
  ) u_por (
    .clk       (clk),
    .supply_ok (supply_ok),
    .por_en    (por_en),
    .por_hold  (por_hold)
  );

  assign rst_next = ~pin_ok | por_hold;

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n) rst_q <= 1'b1;
    else            rst_q <= rst_next;
  end

  assign core_rst = rst_q;

  rst_defaults #(
    .NUM_TRI   (NUM_TRI),
    .NUM_CLR   (NUM_CLR),
    .SP_W      (SP_W),
    .RAM_BYTES (RAM_BYTES)
  ) u_dflt (
    .clk       (clk),
    .ext_rst_n (ext_rst_n),
    .rst_next  (rst_next),
    .tri_en    (tri_en),
    .hi_drive  (hi_drive),
    .pc_clear  (pc_clear),
    .reg_clear (reg_clear),
    .sp_load   (sp_load),
    .sp_init   (sp_init)
  );
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
  parameter int RAM_BYTES = 64,
  parameter int NUM_TRI   = 4,
  parameter int NUM_CLR   = 6,
  parameter int SP_W      = 8
) (
  input logic               clk,
  input logic               ext_rst_n,
  input logic               supply_ok,
  input logic               por_en,
  input logic               core_rst,
  input logic               halt_exit,
  input logic [NUM_TRI-1:0] tri_en,
  input logic               hi_drive,
  input logic               pc_clear,
  input logic [NUM_CLR-1:0] reg_clear,
  input logic               sp_load,
  input logic [SP_W-1:0]    sp_init
);
  logic [2:0] age = 3'd0;
  logic       ready;
  logic [3:0] sup_hi_cnt = 4'd0;
  logic [3:0] low_cnt = 4'd0;

  always_ff @(posedge clk) begin
    if (age != 3'd7) age <= age + 3'd1;
    if (!supply_ok)              sup_hi_cnt <= 4'd0;
    else if (sup_hi_cnt != 4'hF) sup_hi_cnt <= sup_hi_cnt + 4'd1;
    if (supply_ok || !por_en)    low_cnt <= 4'd0;
    else if (low_cnt != 4'hF)    low_cnt <= low_cnt + 4'd1;
  end
  assign ready = (age >= 3'd5);

  AST_PIN_ASSERT: assert property (@(posedge clk) disable iff (!ready)
    !ext_rst_n |-> core_rst); // R1
  AST_SYNC_RELEASE: assert property (@(posedge clk) disable iff (!ready)
    $fell(core_rst) |-> ext_rst_n && $past(ext_rst_n) && $past(ext_rst_n, 2)); // R2
  AST_POR_HOLD: assert property (@(posedge clk) disable iff (!ready)
    low_cnt >= 4'd5 |-> core_rst); // R3
  AST_NO_POR_EFFECT: assert property (@(posedge clk) disable iff (!ready)
    !$past(por_en) && ext_rst_n && $past(ext_rst_n) && $past(ext_rst_n, 2)
    && $past(ext_rst_n, 3) |-> !core_rst); // R4
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!ready)
    $rose(core_rst) && ext_rst_n && $past(ext_rst_n) |-> sup_hi_cnt < 4'd5); // R5
  AST_PORT_DEFAULTS: assert property (@(posedge clk) disable iff (!ready)
    tri_en == {NUM_TRI{core_rst}} && hi_drive == core_rst); // R7
  AST_STATE_DEFAULTS: assert property (@(posedge clk) disable iff (!ready)
    pc_clear == core_rst && sp_load == core_rst && reg_clear == {NUM_CLR{core_rst}}
    && sp_init == SP_W'(RAM_BYTES - 17)); // R8
  AST_HALT_IN_RESET: assert property (@(posedge clk) disable iff (!ready)
    halt_exit |-> core_rst); // R9
  AST_HALT_SINGLE: assert property (@(posedge clk) disable iff (!ready)
    halt_exit |=> !halt_exit); // R9
endmodule

bind rst_seq rst_seq_chk #(
  .RAM_BYTES (RAM_BYTES),
  .NUM_TRI   (NUM_TRI),
  .NUM_CLR   (NUM_CLR),
  .SP_W      (SP_W)
) u_chk (
  .clk       (clk),
  .ext_rst_n (ext_rst_n),
  .supply_ok (supply_ok),
  .por_en    (por_en),
  .core_rst  (core_rst),
  .halt_exit (halt_exit),
  .tri_en    (tri_en),
  .hi_drive  (hi_drive),
  .pc_clear  (pc_clear),
  .reg_clear (reg_clear),
  .sp_load   (sp_load),
  .sp_init   (sp_init)
);

// File: tb/sim_rst_seq.sv
`timescale 1ns/1ps
module sim_rst_seq;
  localparam int CYC_DIV   = 2;
  localparam int TICKS     = 4096;
  localparam int RAM_BYTES = 64;
  localparam int POR_EDGES = TICKS * CYC_DIV + 4;

  logic       clk = 1'b0;
  logic       ext_rst_n = 1'b1;
  logic       supply_ok = 1'b0;
  logic       por_en = 1'b1;
  logic       core_rst, halt_exit, hi_drive, pc_clear, sp_load;
  logic [3:0] tri_en;
  logic [5:0] reg_clear;
  logic [7:0] sp_init;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  rst_seq #(.CYC_DIV(CYC_DIV), .RAM_BYTES(RAM_BYTES)) u0 (
    .clk(clk), .ext_rst_n(ext_rst_n), .supply_ok(supply_ok), .por_en(por_en),
    .core_rst(core_rst), .halt_exit(halt_exit), .tri_en(tri_en), .hi_drive(hi_drive),
    .pc_clear(pc_clear), .reg_clear(reg_clear), .sp_load(sp_load), .sp_init(sp_init)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(1'b0, "WATCHDOG", "run length", cycles, 150000);
      finish_run();
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Count rising edges until core_rst is seen low, sampling at each falling edge.
  task automatic count_release(output int n, input int limit);
    n = 0;
    while (n < limit) begin
      @(posedge clk); @(negedge clk);
      n++;
      if (!core_rst) break;
    end
  endtask

  task automatic chk_defaults(input string rp, input string rs, input bit exp);
    chk(tri_en == {4{exp}} && hi_drive == exp, rp, "port defaults",
        int'({tri_en, hi_drive}), int'({5{exp}}));
    chk(pc_clear == exp && sp_load == exp && reg_clear == {6{exp}}, rs, "state defaults",
        int'({pc_clear, sp_load, reg_clear}), int'({8{exp}}));
  endtask

  task automatic t_reset_state();
    #1 ext_rst_n = 1'b0;
    #1;
    chk(core_rst == 1'b1, "R1", "core_rst on pin low before any clock", core_rst, 1);
    chk_defaults("R7", "R8", 1'b1);
    chk(sp_init == 8'h2F, "R8", "sp_init", sp_init, 8'h2F);
    idle(4);
    chk(core_rst == 1'b1, "R1", "core_rst while pin held low", core_rst, 1);
  endtask

  task automatic t_por_stretch();
    int n;
    ext_rst_n = 1'b1;
    idle(6);
    chk(core_rst == 1'b1, "R3", "held while supply low", core_rst, 1);
    supply_ok = 1'b1;
    count_release(n, POR_EDGES + 50);
    chk(n == POR_EDGES, "R3", "release edge after supply rise", n, POR_EDGES);
    chk_defaults("R7", "R8", 1'b0);
  endtask

  task automatic t_oneshot();
    bit stayed = 1'b1;
    idle(20);
    por_en = 1'b0;
    idle(5);
    por_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (core_rst) stayed = 1'b0;
    end
    chk(stayed, "R5", "no new reset after stretch", core_rst, 0);
  endtask

  task automatic t_pin_reset();
    int n;
    bit extra = 1'b0;
    @(negedge clk);
    ext_rst_n = 1'b0;
    #1;
    chk(core_rst == 1'b1, "R1", "async assert mid cycle", core_rst, 1);
    chk(halt_exit == 1'b0, "R9", "no pulse before edge", halt_exit, 0);
    @(negedge clk);
    chk(halt_exit == 1'b1, "R9", "pulse after first edge", halt_exit, 1);
    @(negedge clk);
    chk(halt_exit == 1'b0, "R9", "pulse lasts one clock", halt_exit, 0);
    idle(3);
    ext_rst_n = 1'b1;
    count_release(n, 20);
    chk(n == 3, "R2", "release edges after pin high", n, 3);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (halt_exit) extra = 1'b1;
    end
    chk(!extra, "R9", "no pulse on release", extra, 0);
  endtask

  task automatic t_no_por();
    bit any = 1'b0;
    por_en = 1'b0;
    idle(2);
    supply_ok = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (core_rst) any = 1'b1;
    end
    chk(!any, "R4", "no reset with supply low and path off", any, 0);
    supply_ok = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (core_rst) any = 1'b1;
    end
    chk(!any, "R4", "no reset on supply rise with path off", any, 0);
    por_en = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (core_rst) any = 1'b1;
    end
    chk(!any, "R5", "enable later does not start stretch", any, 0);
  endtask

  task automatic t_abort();
    supply_ok = 1'b0;
    idle(6);
    chk(core_rst == 1'b1, "R6", "re-armed by supply drop", core_rst, 1);
    supply_ok = 1'b1;
    idle(100);
    chk(core_rst == 1'b1, "R3", "still held mid stretch", core_rst, 1);
    por_en = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(core_rst == 1'b0, "R10", "cancel releases on next edge", core_rst, 0);
    idle(3);
    por_en = 1'b1;
  endtask

  task automatic t_rearm();
    int n;
    idle(5);
    supply_ok = 1'b0;
    idle(4);
    chk(core_rst == 1'b1, "R6", "reset within four clocks of drop", core_rst, 1);
    idle(4);
    supply_ok = 1'b1;
    count_release(n, POR_EDGES + 50);
    chk(n == POR_EDGES, "R6", "full stretch after re-arm", n, POR_EDGES);
  endtask

  initial begin
    t_reset_state();
    t_por_stretch();
    t_oneshot();
    t_pin_reset();
    t_no_por();
    t_abort();
    t_rearm();
    finish_run();
  end
endmodule